// File: doc/BRIEF.md
# Endurance-Aware Cleaning Policy

This block sits beside the garbage-collection engine of a flash translation layer and tells it what to do with a block the engine proposes to clean. It keeps a remaining-life count for every physical block and lowers that count by one on each erase. When a cleaning candidate arrives, the block's remaining life is compared against two programmable limits. A healthy block is cleaned in the usual way. A worn block is cleaned and then marked to receive cold (rarely rewritten) data, so that it sees fewer future erases. A block that is close to exhaustion is only accepted one time in four, and a pseudo-random sequence makes that choice. A block whose life has run out is retired and is never accepted again.

The aim is to even out erase counts across blocks. Blocks wear independently, so hot data would otherwise exhaust a few blocks long before the rest.

Top module: `wear_policy`

## Requirements
- R1: After reset every block holds a remaining life of INIT_LIFE (default 100), no block is retired, `dec_vld` is low, the migrate limit is MIG_INIT (default 40) and the throttle limit is THR_INIT (default 10).
- R2: A cycle with `erase_vld` high lowers the remaining life of block `erase_blk` by one and leaves every other block unchanged.
- R3: `dec_vld` is high in exactly the cycle after a cycle with `cand_vld` high. The decision uses the remaining life, limits and random value registered before that candidate cycle's edge, so an erase or limit write in the same cycle does not affect it.
- R4: A non-retired candidate whose remaining life is at or above the migrate limit gets code 0 (clean) with `migrate_cold` low.
- R5: A candidate whose remaining life is below the migrate limit but at or above the throttle limit gets code 1 (clean, then fill with cold data) with `migrate_cold` high.
- R6: A non-retired candidate whose remaining life is below the throttle limit gets code 1 with `migrate_cold` high when bits [1:0] of the random register are both zero, and otherwise gets code 2 (skip) with `migrate_cold` low.
- R7: The random register is 16 bits wide and starts at 16'hACE1. On each candidate cycle it shifts left by one, and the new bit 0 is the XOR of bits 15, 13, 12 and 10. It holds in every other cycle.
- R8: An erase that brings a block's remaining life to zero retires the block. The count then stays at zero under further erases, and every later candidate for that block gets code 3 (retired) with `migrate_cold` low.
- R9: A write with `cfg_we` high and `cfg_sel` 0 sets the migrate limit, and one with `cfg_sel` 1 sets the throttle limit. A write that would leave the throttle limit not strictly below the migrate limit is ignored.
- R10: `migrate_cold` is high only together with `dec_vld` high and code 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| erase_vld | input | 1 | An erase of one block completed this cycle |
| erase_blk | input | IDX_W (4) | Index of the erased block |
| cand_vld | input | 1 | A cleaning candidate is offered this cycle |
| cand_blk | input | IDX_W (4) | Index of the candidate block |
| cfg_we | input | 1 | Limit write strobe |
| cfg_sel | input | 1 | 0 selects the migrate limit, 1 the throttle limit |
| cfg_data | input | LIFE_W (16) | New limit value |
| dec_vld | output | 1 | Decision valid |
| dec_code | output | 2 | 0 clean, 1 clean with cold fill, 2 skip, 3 retired |
| migrate_cold | output | 1 | Fill the cleaned block with cold data |

## Verification
The bench drives one block down through each boundary: life equal to the migrate limit (it must still be cleaned normally), one below it, equal to the throttle limit, one below that, and finally zero. An off-by-one compare would move a decision across one of these lines. An erase and a candidate for the same block in the same cycle expose a design that decides on the updated count. Limit writes that would invert the two limits are offered, and a design that accepts them changes the later decisions. Throttled decisions are compared against a separately written random-sequence model, so a wrong tap, seed or advance rule shows up as a mismatched skip or accept. Further erases after retirement reveal a count that wraps around instead of saturating.

// File: rtl/wear_pkg.sv
package wear_pkg;
  localparam int unsigned WP_LIFE_W = 16;
  localparam int unsigned WP_RND_W  = 16;

  typedef enum logic [1:0] {
    DEC_CLEAN   = 2'd0,
    DEC_MIGRATE = 2'd1,
    DEC_SKIP    = 2'd2,
    DEC_RETIRED = 2'd3
  } dec_e;

  // Priority: retired, then healthy, then worn, then near-exhausted lottery.
  function automatic dec_e judge(input logic retired,
                                 input logic at_or_above_mig,
                                 input logic below_thr,
                                 input logic lucky);
    if (retired)              return DEC_RETIRED;
    else if (at_or_above_mig) return DEC_CLEAN;
    else if (!below_thr)      return DEC_MIGRATE;
    else if (lucky)           return DEC_MIGRATE;
    else                      return DEC_SKIP;
  endfunction

  // Lottery draw: accept when the two low random bits are zero.
  function automatic logic draw_ok(input logic [1:0] low_bits);
    return low_bits == 2'b00;
  endfunction
endpackage

// File: rtl/wl_life_bank.sv
module wl_life_bank #(
  parameter int unsigned NUM_BLK   = 16,
  parameter int unsigned LIFE_W    = 16,
  parameter int unsigned INIT_LIFE = 100,
  localparam int unsigned IDX_W    = $clog2(NUM_BLK)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     erase_vld,
  input  logic [IDX_W-1:0]         erase_blk,
  input  logic [IDX_W-1:0]         rd_blk,
  output logic [LIFE_W-1:0]        rd_life,
  output logic                     rd_retired,
  output logic [NUM_BLK-1:0]       retired_vec,
  output logic [NUM_BLK-1:0]       erase_hit
);
  logic [LIFE_W-1:0] life_q [NUM_BLK];

  for (genvar g = 0; g < NUM_BLK; g++) begin : g_blk
    assign erase_hit[g] = erase_vld && (erase_blk == IDX_W'(g)) && (life_q[g] != '0);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        life_q[g]      <= LIFE_W'(INIT_LIFE);
        retired_vec[g] <= 1'b0;
      end else if (erase_hit[g]) begin
        life_q[g] <= life_q[g] - LIFE_W'(1);
        if (life_q[g] == LIFE_W'(1)) retired_vec[g] <= 1'b1;
      end
    end
  end

  assign rd_life    = life_q[rd_blk];
  assign rd_retired = retired_vec[rd_blk];
endmodule

// File: rtl/wl_lfsr.sv
module wl_lfsr #(
  parameter int unsigned W    = 16,
  parameter logic [W-1:0] SEED = 16'hACE1,
  parameter logic [W-1:0] TAPS = 16'hB400
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  output logic [W-1:0] q
);
  logic fb;
  assign fb = ^(q & TAPS);

  always_ff @(posedge clk) begin
    if (!rst_n)   q <= SEED;
    else if (adv) q <= {q[W-2:0], fb};
  end
endmodule

// File: rtl/wl_judge.sv
module wl_judge #(
  parameter int unsigned LIFE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [LIFE_W-1:0] life,
  input  logic              retired,
  input  logic [LIFE_W-1:0] mig_lim,
  input  logic [LIFE_W-1:0] thr_lim,
  input  logic [1:0]        rnd_low,
  output logic              vld_q,
  output wear_pkg::dec_e    code_q,
  output logic              cold_q
);
  import wear_pkg::*;
  logic above_mig, below_thr, lucky;
  dec_e code_d;

  assign above_mig = life >= mig_lim;
  assign below_thr = life < thr_lim;
  assign lucky     = draw_ok(rnd_low);
  assign code_d    = judge(retired, above_mig, below_thr, lucky);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      code_q <= DEC_CLEAN;
      cold_q <= 1'b0;
    end else begin
      vld_q  <= go;
      code_q <= go ? code_d : DEC_CLEAN;
      cold_q <= go && (code_d == DEC_MIGRATE);
    end
  end
endmodule

// File: rtl/wear_policy.sv
module wear_policy #(
  parameter int unsigned NUM_BLK   = 16,
  parameter int unsigned LIFE_W    = wear_pkg::WP_LIFE_W,
  parameter int unsigned INIT_LIFE = 100,
  parameter int unsigned MIG_INIT  = 40,
  parameter int unsigned THR_INIT  = 10,
  localparam int unsigned IDX_W    = $clog2(NUM_BLK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase_vld,
  input  logic [IDX_W-1:0]  erase_blk,
  input  logic              cand_vld,
  input  logic [IDX_W-1:0]  cand_blk,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [LIFE_W-1:0] cfg_data,
  output logic              dec_vld,
  output logic [1:0]        dec_code,
  output logic              migrate_cold
);
  import wear_pkg::*;
  localparam int unsigned RND_W = WP_RND_W;

  logic [LIFE_W-1:0]  mig_q, thr_q;
  logic [LIFE_W-1:0]  cand_life;
  logic               cand_retired;
  logic [NUM_BLK-1:0] retired_vec, erase_hit;
  logic [RND_W-1:0]   lfsr_q;
  logic               cfg_ok;
  dec_e               code_q;

  // A limit write is taken only if it keeps throttle strictly below migrate.
  assign cfg_ok = cfg_sel ? (cfg_data < mig_q) : (cfg_data > thr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mig_q <= LIFE_W'(MIG_INIT);
      thr_q <= LIFE_W'(THR_INIT);
    end else if (cfg_we && cfg_ok) begin
      if (cfg_sel) thr_q <= cfg_data;
      else         mig_q <= cfg_data;
    end
  end

  wl_life_bank #(.NUM_BLK(NUM_BLK), .LIFE_W(LIFE_W), .INIT_LIFE(INIT_LIFE)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .erase_vld(erase_vld), .erase_blk(erase_blk),
    .rd_blk(cand_blk), .rd_life(cand_life), .rd_retired(cand_retired),
    .retired_vec(retired_vec), .erase_hit(erase_hit)
  );

  wl_lfsr #(.W(RND_W)) u_rnd (
    .clk(clk), .rst_n(rst_n), .adv(cand_vld), .q(lfsr_q)
  );

  wl_judge #(.LIFE_W(LIFE_W)) u_judge (
    .clk(clk), .rst_n(rst_n), .go(cand_vld),
    .life(cand_life), .retired(cand_retired),
    .mig_lim(mig_q), .thr_lim(thr_q), .rnd_low(lfsr_q[1:0]),
    .vld_q(dec_vld), .code_q(code_q), .cold_q(migrate_cold)
  );

  assign dec_code = code_q;
endmodule

// File: rtl/wear_policy_chk.sv
module wear_policy_chk #(
  parameter int unsigned NUM_BLK = 16,
  parameter int unsigned LIFE_W  = 16,
  localparam int unsigned IDX_W  = $clog2(NUM_BLK)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cand_vld,
  input logic [IDX_W-1:0]   cand_blk,
  input logic               dec_vld,
  input logic [1:0]         dec_code,
  input logic               migrate_cold,
  input logic [LIFE_W-1:0]  mig_q,
  input logic [LIFE_W-1:0]  thr_q,
  input logic [NUM_BLK-1:0] retired_vec,
  input logic [15:0]        lfsr_q
);
  p_dec_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cand_vld |=> dec_vld);
  p_no_stray_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cand_vld |=> !dec_vld);
  p_cold_only_mig_r10: assert property (@(posedge clk) disable iff (!rst_n)
    migrate_cold |-> (dec_vld && dec_code == 2'd1));
  p_retired_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_vld && retired_vec[cand_blk]) |=> (dec_vld && dec_code == 2'd3));
  p_retired_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(retired_vec) & ~retired_vec) == '0));
  p_limit_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    thr_q < mig_q);
  p_rnd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cand_vld |=> $stable(lfsr_q));
  p_rnd_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != 16'd0);
endmodule

bind wear_policy wear_policy_chk #(.NUM_BLK(NUM_BLK), .LIFE_W(LIFE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cand_vld(cand_vld), .cand_blk(cand_blk),
  .dec_vld(dec_vld), .dec_code(dec_code), .migrate_cold(migrate_cold),
  .mig_q(mig_q), .thr_q(thr_q), .retired_vec(retired_vec), .lfsr_q(lfsr_q)
);

// File: tb/wear_policy_tb.sv
module wear_policy_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic erase_vld = 0, cand_vld = 0, cfg_we = 0, cfg_sel = 0;
  logic [3:0] erase_blk = 0, cand_blk = 0;
  logic [15:0] cfg_data = 0;
  logic dec_vld, migrate_cold;
  logic [1:0] dec_code;

  int total = 0, bad = 0;
  int life_m [16];
  bit ret_m [16];
  int mig_m, thr_m;
  logic [15:0] rnd_m;

  always #10ns clk = ~clk;

  wear_policy u_dut (
    .clk(clk), .rst_n(rst_n), .erase_vld(erase_vld), .erase_blk(erase_blk),
    .cand_vld(cand_vld), .cand_blk(cand_blk), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .dec_vld(dec_vld), .dec_code(dec_code),
    .migrate_cold(migrate_cold)
  );

  function automatic logic [15:0] rnd_next(input logic [15:0] s);
    logic b;
    b = s[15] ^ s[13] ^ s[12] ^ s[10];
    return (s << 1) | 16'(b);
  endfunction

  function automatic int expect_code(input int blk);
    if (ret_m[blk]) return 3;
    if (life_m[blk] >= mig_m) return 0;
    if (life_m[blk] >= thr_m) return 1;
    return (rnd_m[1:0] == 2'b00) ? 1 : 2;
  endfunction

  function automatic string code_tag(input int c, input int blk);
    if (c == 3) return "R8";
    if (c == 0) return "R4";
    if (life_m[blk] >= thr_m) return "R5";
    return "R6";
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input string tag_ovr);
    bit ev; int ec, em; string tg;
    ev = cand_vld;
    ec = expect_code(cand_blk);
    em = (ec == 1);
    tg = (tag_ovr != "") ? tag_ovr : code_tag(ec, cand_blk);
    @(posedge clk);
    if (cand_vld) rnd_m = rnd_next(rnd_m);
    if (erase_vld && life_m[erase_blk] > 0) begin
      life_m[erase_blk]--;
      if (life_m[erase_blk] == 0) ret_m[erase_blk] = 1;
    end
    if (cfg_we) begin
      if (cfg_sel && int'(cfg_data) < mig_m) thr_m = cfg_data;
      else if (!cfg_sel && int'(cfg_data) > thr_m) mig_m = cfg_data;
    end
    @(negedge clk);
    chk("R3 dec_vld", dec_vld, ev);
    if (ev) begin
      chk({tg, " code"}, dec_code, ec);
      chk({"R10 ", tg, " cold"}, migrate_cold, em);
    end
  endtask

  task automatic idle();
    erase_vld = 0; cand_vld = 0; cfg_we = 0;
  endtask

  task automatic do_erase(input int blk, input int n);
    for (int i = 0; i < n; i++) begin
      erase_vld = 1; erase_blk = 4'(blk); step(""); idle();
    end
  endtask

  task automatic do_cand(input int blk, input string tag);
    cand_vld = 1; cand_blk = 4'(blk); step(tag); idle();
  endtask

  task automatic do_cfg(input bit sel, input int d);
    cfg_we = 1; cfg_sel = sel; cfg_data = 16'(d); step(""); idle();
  endtask

  initial begin
    #(20ns * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) begin life_m[i] = 100; ret_m[i] = 0; end
    mig_m = 40; thr_m = 10; rnd_m = 16'hACE1;
    repeat (3) @(negedge clk);
    chk("R1 dec_vld in reset", dec_vld, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 dec_vld after reset", dec_vld, 0);
    for (int b = 0; b < 16; b++) do_cand(b, "R1");

    // Boundaries on block 3; block 4 must stay untouched (R2).
    do_erase(3, 60);
    do_cand(3, "R4 at limit");
    do_cand(4, "R2 neighbour");
    do_erase(3, 1);
    do_cand(3, "R5 below migrate");
    // Same-cycle erase and candidate: decision uses pre-erase life (R3).
    do_erase(3, 28);
    erase_vld = 1; erase_blk = 3; cand_vld = 1; cand_blk = 3; step("R3 same cycle"); idle();
    do_cand(3, "R5 at throttle");
    // Rejected limit writes (R9): life 10 must stay a cold-fill decision.
    do_cfg(0, 5);
    do_cfg(1, 200);
    do_cfg(1, 40);
    do_cand(3, "R9 rejected writes");
    do_cfg(1, 20);
    do_cand(3, "R9 accepted throttle");
    do_cfg(1, 10);
    do_erase(3, 1);
    for (int i = 0; i < 12; i++) do_cand(3, "R6 lottery");
    do_erase(3, 9);
    do_cand(3, "R8 retired");
    do_erase(3, 5);
    do_cand(3, "R8 saturated");

    // Constrained random phase.
    for (int n = 0; n < 8000; n++) begin
      erase_vld = ($urandom_range(0, 99) < 60);
      erase_blk = 4'($urandom_range(0, 15));
      cand_vld  = ($urandom_range(0, 99) < 50);
      cand_blk  = 4'($urandom_range(0, 15));
      cfg_we    = ($urandom_range(0, 99) < 2);
      cfg_sel   = 1'($urandom_range(0, 1));
      cfg_data  = 16'($urandom_range(0, 110));
      step("");
    end
    idle();
    for (int b = 0; b < 16; b++) do_cand(b, "");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule